// File: doc/BRIEF.md
# PCIe Transmit Credit Gate

This block decides whether the transaction layer packet currently offered for transmission fits into the link partner's receive buffers. It holds credit state for six flow-control pools: header and data credits for each of the posted, non-posted and completion classes. The link side advertises each pool's room as an absolute, wrapping 16-bit limit. These limits arrive on a valid-qualified 19-bit update word. The block keeps its own wrapping count of credits it has used from each pool.

A transmit scheduler presents a request: a class and a payload length in dwords. Every packet needs one header credit. It also needs one data credit for each started group of four payload dwords. The block raises `gnt` in the same cycle when both pools of that class have enough room. On the clock edge that ends a granted cycle, the block charges the request's cost to those two pools. A request that is not granted is simply held by the scheduler and costs nothing. This gate works alongside the ordinary ready/valid handshake of the data path.

Top module: `pcie_tx_credit_gate`

## Requirements
- R1: A limit update is taken only on a clock edge where `lim_vld` is high. When `lim_vld` is low, the value on `lim_data` has no effect on any later grant decision.
- R2: `lim_data[15:0]` is the limit and `lim_data[18:16]` the pool code. The codes are: 000 posted header, 001 non-posted header, 010 completion header, 100 posted data, 101 non-posted data, 110 completion data. An update with code 011 or 111 is ignored.
- R3: After reset every limit and every used count is 0, so no request is granted until its pools receive nonzero limits.
- R4: Room in a pool is (limit − used) mod 65536. Grant decisions stay correct when the limit or the used count wraps past 65535.
- R5: A request needs ceil(`req_dw` / 4) data credits and one header credit. It is granted only when both pools of its class have at least that much room.
- R6: A request with `req_dw` = 0 checks and charges header credit only. Its class's data pool is neither tested nor changed.
- R7: `req_cls` encodes 0 posted, 1 non-posted, 2 completion. Code 3 and a low `req_vld` are never granted.
- R8: `gnt` is combinational from the request inputs and the current state. On the edge ending a granted cycle, the class's header used count rises by 1 and its data used count rises by the data need.
- R9: A request that is presented but not granted charges no credits.
- R10: A limit update in the same cycle as a grant is applied together with the grant's charge. Neither change is lost.
- R11: An accepted limit update first affects `gnt` in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_vld | input | 1 | Limit update valid |
| lim_data | input | 19 | Pool code [18:16], absolute limit [15:0] |
| req_vld | input | 1 | A packet is waiting to be sent |
| req_cls | input | 2 | Packet class: 0 posted, 1 non-posted, 2 completion |
| req_dw | input | DW_W (11) | Payload length in dwords |
| gnt | output | 1 | Packet may be released this cycle |

## Verification
The hardest situation to reach from the ports is a used count that wraps past 65535 while the advertised limit has wrapped too. This needs tens of thousands of data credits granted in a single class. The stimulus gets there by raising the completion limits in steps, each time by exactly one maximum-length packet, and then granting that packet. It repeats this well over a hundred times, so both counters cross zero while the room stays small. A random phase then mixes cumulative updates, reserved codes, same-cycle updates and grants, and stalled requests against the behavioural model.

// File: rtl/txcg_pkg.sv
package txcg_pkg;
  localparam int CRED_W = 16;
  localparam int NPOOL  = 6;

  typedef enum logic [1:0] {
    CLS_POSTED = 2'd0,
    CLS_NONPOST = 2'd1,
    CLS_CPL = 2'd2,
    CLS_NONE = 2'd3
  } pkt_cls_e;

  // pool code with low bits 11 carries no pool
  function automatic logic code_reserved(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

  // header pools occupy slots 0..2, data pools slots 3..5
  function automatic logic [2:0] slot_of(input logic [2:0] code);
    return code[2] ? (3'd3 + {1'b0, code[1:0]}) : {1'b0, code[1:0]};
  endfunction

  function automatic logic [CRED_W-1:0] room(input logic [CRED_W-1:0] lim,
                                             input logic [CRED_W-1:0] used);
    return lim - used;
  endfunction

  function automatic logic [CRED_W-1:0] dw_to_credits(input logic [CRED_W-1:0] dw);
    logic [CRED_W:0] sum;
    sum = {1'b0, dw} + (CRED_W+1)'(3);
    return sum[CRED_W:2];
  endfunction
endpackage

// File: rtl/txcg_limit_store.sv
module txcg_limit_store
  import txcg_pkg::*;
#(
  parameter int CW = CRED_W,
  parameter int NP = NPOOL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_vld,
  input  logic [2:0]            upd_code,
  input  logic [CW-1:0]         upd_val,
  output logic [NP-1:0][CW-1:0] lim_q
);
  logic             upd_ok;
  logic [2:0]       upd_slot;

  assign upd_ok   = upd_vld && !code_reserved(upd_code);
  assign upd_slot = slot_of(upd_code);

  for (genvar i = 0; i < NP; i++) begin : g_pool
    always_ff @(posedge clk) begin
      if (!rst_n)
        lim_q[i] <= '0;
      else if (upd_ok && (upd_slot == 3'(i)))
        lim_q[i] <= upd_val;
    end
  end
endmodule

// File: rtl/txcg_used_ctr.sv
module txcg_used_ctr
  import txcg_pkg::*;
#(
  parameter int CW = CRED_W,
  parameter int NP = NPOOL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [1:0]            take_cls,
  input  logic [CW-1:0]         take_data,
  output logic [NP-1:0][CW-1:0] used_q
);
  localparam int NCLS = NP / 2;

  for (genvar i = 0; i < NP; i++) begin : g_pool
    localparam logic [1:0] MYCLS = 2'(i % NCLS);
    localparam bit IS_DATA = (i >= NCLS);
    logic [CW-1:0] step;
    assign step = IS_DATA ? take_data : CW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n)
        used_q[i] <= '0;
      else if (take && (take_cls == MYCLS))
        used_q[i] <= used_q[i] + step;
    end
  end
endmodule

// File: rtl/txcg_decide.sv
module txcg_decide
  import txcg_pkg::*;
#(
  parameter int CW = CRED_W,
  parameter int NP = NPOOL,
  parameter int DW_W = 11
) (
  input  logic                  req_vld,
  input  logic [1:0]            req_cls,
  input  logic [DW_W-1:0]       req_dw,
  input  logic [NP-1:0][CW-1:0] lim_q,
  input  logic [NP-1:0][CW-1:0] used_q,
  output logic                  gnt,
  output logic [CW-1:0]         data_need
);
  localparam int NCLS = NP / 2;

  logic [CW-1:0] hdr_room, data_room;
  logic [2:0]    hslot, dslot;
  logic          cls_ok, hdr_ok, data_ok;

  assign cls_ok    = (req_cls != CLS_NONE);
  assign hslot     = {1'b0, req_cls};
  assign dslot     = 3'(NCLS) + {1'b0, req_cls};
  assign data_need = dw_to_credits(CW'(req_dw));

  always_comb begin
    hdr_room  = '0;
    data_room = '0;
    if (cls_ok) begin
      hdr_room  = room(lim_q[hslot], used_q[hslot]);
      data_room = room(lim_q[dslot], used_q[dslot]);
    end
  end

  assign hdr_ok  = hdr_room != '0;
  assign data_ok = (data_need == '0) || (data_room >= data_need);
  assign gnt     = req_vld && cls_ok && hdr_ok && data_ok;
endmodule

// File: rtl/pcie_tx_credit_gate.sv
module pcie_tx_credit_gate
  import txcg_pkg::*;
#(
  parameter int DW_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lim_vld,
  input  logic [18:0]     lim_data,
  input  logic            req_vld,
  input  logic [1:0]      req_cls,
  input  logic [DW_W-1:0] req_dw,
  output logic            gnt
);
  localparam int CW = CRED_W;
  localparam int NP = NPOOL;

  logic [2:0]            lim_code;
  logic [CW-1:0]         lim_val;
  logic [NP-1:0][CW-1:0] lim_q;
  logic [NP-1:0][CW-1:0] used_q;
  logic [CW-1:0]         data_need;
  logic                  grant_ev;

  assign lim_code = lim_data[18:16];
  assign lim_val  = lim_data[15:0];

  txcg_limit_store #(.CW(CW), .NP(NP)) u_lim (
    .clk(clk), .rst_n(rst_n), .upd_vld(lim_vld), .upd_code(lim_code),
    .upd_val(lim_val), .lim_q(lim_q)
  );

  txcg_decide #(.CW(CW), .NP(NP), .DW_W(DW_W)) u_dec (
    .req_vld(req_vld), .req_cls(req_cls), .req_dw(req_dw),
    .lim_q(lim_q), .used_q(used_q), .gnt(grant_ev), .data_need(data_need)
  );

  txcg_used_ctr #(.CW(CW), .NP(NP)) u_used (
    .clk(clk), .rst_n(rst_n), .take(grant_ev), .take_cls(req_cls),
    .take_data(data_need), .used_q(used_q)
  );

  assign gnt = grant_ev;
endmodule

// File: rtl/txcg_chk.sv
module txcg_chk
  import txcg_pkg::*;
#(
  parameter int CW = CRED_W,
  parameter int NP = NPOOL,
  parameter int DW_W = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lim_vld,
  input logic [2:0]            lim_code,
  input logic [CW-1:0]         lim_val,
  input logic                  req_vld,
  input logic [1:0]            req_cls,
  input logic [DW_W-1:0]       req_dw,
  input logic                  gnt,
  input logic [NP-1:0][CW-1:0] lim_q,
  input logic [NP-1:0][CW-1:0] used_q
);
  localparam int NCLS = NP / 2;

  assert_gnt_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> (req_vld && req_cls != 2'd3));

  assert_idle_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_vld |=> $stable(lim_q));

  assert_reserved_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_vld && lim_code[1:0] == 2'b11) |=> $stable(lim_q));

  assert_stall_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt |=> $stable(used_q));

  assert_hdr_charge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |=> (used_q[$past(req_cls)] == $past(used_q[req_cls]) + CW'(1)));

  assert_no_data_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && req_dw == '0) |=> $stable(used_q[NP-1:NCLS]));

  assert_update_with_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && lim_vld && lim_code[1:0] != 2'b11)
      |=> (lim_q[slot_of($past(lim_code))] == $past(lim_val)));
endmodule

bind pcie_tx_credit_gate txcg_chk #(.CW(CW), .NP(NP), .DW_W(DW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lim_vld(lim_vld), .lim_code(lim_code),
  .lim_val(lim_val), .req_vld(req_vld), .req_cls(req_cls), .req_dw(req_dw),
  .gnt(gnt), .lim_q(lim_q), .used_q(used_q)
);

// File: tb/pcie_tx_credit_gate_tb_top.sv
`timescale 1ns/1ps
module pcie_tx_credit_gate_tb_top;
  localparam int DW_W = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lim_vld = 1'b0;
  logic [18:0]     lim_data = '0;
  logic            req_vld = 1'b0;
  logic [1:0]      req_cls = '0;
  logic [DW_W-1:0] req_dw = '0;
  logic            gnt;

  int total = 0;
  int bad = 0;
  int lim_m[6];
  int used_m[6];
  bit done = 0;

  always #2 clk = ~clk;

  pcie_tx_credit_gate #(.DW_W(DW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lim_vld(lim_vld), .lim_data(lim_data),
    .req_vld(req_vld), .req_cls(req_cls), .req_dw(req_dw), .gnt(gnt)
  );

  function automatic int need_of(int dw);
    return (dw + 3) / 4;
  endfunction

  function automatic bit expect_gnt();
    int c, hr, dr, nd;
    if (!req_vld || req_cls == 2'd3) return 0;
    c  = int'(req_cls);
    nd = need_of(int'(req_dw));
    hr = (lim_m[c] - used_m[c]) & 16'hFFFF;
    dr = (lim_m[3+c] - used_m[3+c]) & 16'hFFFF;
    return (hr >= 1) && (nd == 0 || dr >= nd);
  endfunction

  // check current inputs before the edge, then advance the model across it
  task automatic step(string tag);
    bit e;
    int c, code;
    #1;
    e = expect_gnt();
    total++;
    if (gnt !== e) begin
      bad++;
      $display("FAIL %s: gnt actual=%b expected=%b (cls=%0d dw=%0d)",
               tag, gnt, e, req_cls, req_dw);
    end
    @(posedge clk);
    if (e) begin
      c = int'(req_cls);
      used_m[c]   = (used_m[c] + 1) & 16'hFFFF;
      used_m[3+c] = (used_m[3+c] + need_of(int'(req_dw))) & 16'hFFFF;
    end
    code = int'(lim_data[18:16]);
    if (lim_vld && (code % 4) != 3)
      lim_m[(code / 4) * 3 + (code % 4)] = int'(lim_data[15:0]);
    @(negedge clk);
  endtask

  task automatic set_req(bit v, int c, int dw);
    req_vld = v; req_cls = 2'(c); req_dw = DW_W'(dw);
  endtask

  task automatic set_lim(bit v, int code, int val);
    lim_vld = v; lim_data = {3'(code), 16'(val)};
  endtask

  task automatic bump(int code, int by, string tag);
    int idx;
    idx = (code / 4) * 3 + (code % 4);
    set_lim(1, code, (lim_m[idx] + by) & 16'hFFFF);
    step(tag);
    set_lim(0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin lim_m[i] = 0; used_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: nothing granted from reset
    for (int c = 0; c < 4; c++) begin set_req(1, c, 0); step("R3 reset"); end
    set_req(1, 0, 8); step("R3 reset data");

    // R1: update with valid low ignored
    set_req(0, 0, 0); lim_vld = 0; lim_data = {3'd0, 16'd5}; step("R1 setup");
    lim_data = '0; set_req(1, 0, 0); step("R1 valid low ignored");

    // R2: reserved codes ignored
    set_lim(1, 3, 100); step("R2 code3"); set_lim(1, 7, 100); step("R2 code7");
    set_lim(0, 0, 0);
    for (int c = 0; c < 3; c++) begin set_req(1, c, 4); step("R2 reserved no effect"); end

    // R11: update visible one cycle later; R6 zero payload needs header only
    set_req(1, 0, 0); set_lim(1, 0, 2); step("R11 before edge");
    set_lim(0, 0, 0); step("R6 R11 header only grant");
    set_req(1, 0, 4); step("R5 no data room");
    set_req(0, 0, 0); set_lim(1, 4, 3); step("R2 posted data"); set_lim(0, 0, 0);
    set_req(1, 0, 9); step("R5 ceil 9 dw = 3");
    set_req(1, 0, 1); step("R9 stall header empty");
    step("R9 stall hold"); step("R9 stall hold 2");

    // R10: update concurrent with grant
    bump(1, 1, "R2 np header"); bump(5, 2, "R2 np data");
    set_req(1, 1, 8); set_lim(1, 5, 9); step("R10 grant with update");
    set_lim(0, 0, 0); set_req(1, 1, 4); step("R10 header used");
    bump(1, 3, "R10 header refill");
    set_req(1, 1, 28); step("R10 data room 7");
    set_req(1, 1, 4); step("R10 data exhausted");

    // R7: class 3 never granted even with room
    bump(0, 5, "R7 setup"); set_req(1, 3, 0); step("R7 class3");
    set_req(0, 0, 0); step("R7 req low");

    // R4: wrap of completion pools
    for (int k = 0; k < 140; k++) begin
      set_req(0, 2, 0);
      bump(6, 512, "R4 data limit");
      bump(2, 1, "R4 hdr limit");
      set_req(1, 2, 2047); step("R4 wrap grant");
      step("R4 wrap empty");
    end

    // random mix: R1 R2 R5 R8 R9 R10
    for (int k = 0; k < 4000; k++) begin
      int code, c;
      code = $urandom_range(0, 7);
      c = (code / 4) * 3 + (code % 4);
      if ((code % 4) == 3) c = 0;
      set_lim($urandom_range(0, 2) == 0, code, (lim_m[c] + $urandom_range(0, 40)) & 16'hFFFF);
      set_req($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 160));
      step("R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule